// File: doc/BRIEF.md
# ADC calibration mode sequencer

This block steers the calibration of a sigma-delta converter. A three-bit mode code picks one of five behaviours: plain conversion, self-calibration, the zero and full steps of system calibration, system offset calibration, or background calibration. For every conversion slot the block chooses the core's input (analog input, shorted inputs or reference). It captures the core's results into a zero-scale and a full-scale coefficient register, and it raises an active-low data-ready line when a sequence finishes or a normal output word arrives.

The converter core is outside the block. It reports the end of each output period with a one-cycle `period_tick`, and `conv_data` carries the result of the slot that has just ended. A mode write is held until the next tick. That tick discards the running slot and starts slot 0 of the new mode. Background mode repeats a six-slot cycle: four normal conversions, then a zero-scale slot, then a full-scale slot. It gives one output word per cycle and keeps both coefficients fresh. It stays in force until the mode code is rewritten.

Top module: `cal_sequencer`

## Requirements
- R1: After reset, `drdy_n` is 1, `conv_req` is 0, `src_sel` is 00, and `dout`, `dout_invalid`, `zero_coef` and `full_coef` are all 0.
- R2: In normal mode (code 000, and the unlisted codes 110 and 111), every tick after the starting tick puts `conv_data` on `dout` with `dout_invalid` 0 and drives `drdy_n` low. The source is always the analog input, and the coefficients do not change.
- R3: Self-calibration (code 001) lasts 9 output periods. Source codes are 00 analog, 01 shorted and 10 reference. Periods 1 to 4 use shorted inputs and periods 5 to 9 use the reference. `zero_coef` takes the result at the end of period 4 and `full_coef` takes the result at the end of period 9.
- R4: System calibration uses the analog input for 4 periods per step. Code 010 loads `zero_coef` at the end of period 4. Code 011 loads `full_coef` at the end of period 4. Each step leaves the other coefficient unchanged.
- R5: System offset calibration (code 100) lasts 9 periods. Periods 1 to 4 use the analog input and load `zero_coef` at the end of period 4. Periods 5 to 9 use the reference, and at the end of period 9 `full_coef` becomes that reference result minus `zero_coef`.
- R6: During a calibration sequence `drdy_n` stays high, and it goes low on the tick that ends the last period. The block then returns to normal mode, so the next tick gives a normal output word.
- R7: A one-cycle `rd_ack` with no tick returns `drdy_n` to 1 on the next clock. Without `rd_ack`, `drdy_n` stays low while newer words replace `dout`.
- R8: Background mode (code 101) repeats six slots: four analog slots, then one shorted slot that loads `zero_coef`, then one reference slot that loads `full_coef`. An output word arrives only at the end of the fourth analog slot, so one word comes out every six periods.
- R9: Background mode stays active until the mode is rewritten. The first word after entry has `dout_invalid` set to 1, and later words have it at 0.
- R10: A mode write takes effect on the next tick. That tick discards the result of the running slot, aborts any sequence in progress without touching its remaining coefficients, and starts period 1 of the new mode. `conv_req` is high from the first tick onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | One-cycle strobe that writes `mode_code` |
| mode_code | input | 3 | Mode code selecting the calibration behaviour |
| period_tick | input | 1 | End of an output period from the converter core |
| conv_data | input | DATA_W | Result of the slot that ends with this tick |
| rd_ack | input | 1 | Output word has been read; clears data-ready |
| conv_req | output | 1 | The core is asked to convert (a slot is running) |
| src_sel | output | 2 | Core input for the current slot: 00 analog, 01 shorted, 10 reference |
| zero_coef | output | DATA_W | Zero-scale coefficient |
| full_coef | output | DATA_W | Full-scale coefficient |
| dout | output | DATA_W | Latest output word |
| dout_invalid | output | 1 | Latest word was produced before full-scale calibration |
| drdy_n | output | 1 | Active-low data ready |

## Verification
A wrong slot counter or source schedule shows up within one sequence. Either `drdy_n` falls on the wrong tick, or a coefficient holds a result from the wrong source or period, because the bench's core model tags each result with both the source and the tick number. A stuck mode register or a lost pending write shows up on the first tick after the write: normal words appear during calibration, or background output comes at the wrong rate. A lost first-word flag is visible on the first background output, four periods after entry.

// File: rtl/cal_seq_pkg.sv
package cal_seq_pkg;

   typedef enum logic [2:0] {
      CM_NORM     = 3'd0,
      CM_SELF     = 3'd1,
      CM_SYS_ZERO = 3'd2,
      CM_SYS_FULL = 3'd3,
      CM_SYS_OFS  = 3'd4,
      CM_BACKGND  = 3'd5
   } cal_mode_t;

   typedef enum logic [1:0] {
      SRC_AIN   = 2'b00,
      SRC_SHORT = 2'b01,
      SRC_REF   = 2'b10
   } cal_src_t;

   typedef struct packed {
      cal_src_t src;
      logic     zcap;
      logic     fcap;
      logic     fdiff;
      logic     oevt;
      logic     cevt;
      logic     last;
   } slot_ctl_t;

endpackage

// File: rtl/cal_mode_decode.sv
module cal_mode_decode
   import cal_seq_pkg::*;
(
   input  logic [2:0] code,
   output cal_mode_t  mode
);

   always_comb begin
      case (code)
         3'b001:  mode = CM_SELF;
         3'b010:  mode = CM_SYS_ZERO;
         3'b011:  mode = CM_SYS_FULL;
         3'b100:  mode = CM_SYS_OFS;
         3'b101:  mode = CM_BACKGND;
         default: mode = CM_NORM;
      endcase
   end

endmodule

// File: rtl/cal_slot_plan.sv
module cal_slot_plan
   import cal_seq_pkg::*;
#(
   parameter int ZERO_LEN = 4,
   parameter int SELF_LEN = 9,
   parameter int SYS_LEN  = 4,
   parameter int BG_NORM  = 4,
   parameter int SLOT_W   = 4
) (
   input  cal_mode_t          mode,
   input  logic [SLOT_W-1:0]  slot,
   output slot_ctl_t          ctl
);

   localparam logic [SLOT_W-1:0] ZERO_END  = SLOT_W'(ZERO_LEN);
   localparam logic [SLOT_W-1:0] ZERO_LAST = SLOT_W'(ZERO_LEN - 1);
   localparam logic [SLOT_W-1:0] SELF_LAST = SLOT_W'(SELF_LEN - 1);
   localparam logic [SLOT_W-1:0] SYS_LAST  = SLOT_W'(SYS_LEN - 1);
   localparam logic [SLOT_W-1:0] BG_OUT    = SLOT_W'(BG_NORM - 1);
   localparam logic [SLOT_W-1:0] BG_ZERO   = SLOT_W'(BG_NORM);
   localparam logic [SLOT_W-1:0] BG_FULL   = SLOT_W'(BG_NORM + 1);

   always_comb begin
      ctl.src   = SRC_AIN;
      ctl.zcap  = 1'b0;
      ctl.fcap  = 1'b0;
      ctl.fdiff = 1'b0;
      ctl.oevt  = 1'b0;
      ctl.cevt  = 1'b0;
      ctl.last  = 1'b0;
      case (mode)
         CM_SELF: begin
            ctl.src  = (slot < ZERO_END) ? SRC_SHORT : SRC_REF;
            ctl.zcap = (slot == ZERO_LAST);
            ctl.fcap = (slot == SELF_LAST);
            ctl.last = (slot == SELF_LAST);
            ctl.cevt = (slot == SELF_LAST);
         end
         CM_SYS_ZERO: begin
            ctl.zcap = (slot == SYS_LAST);
            ctl.last = (slot == SYS_LAST);
            ctl.cevt = (slot == SYS_LAST);
         end
         CM_SYS_FULL: begin
            ctl.fcap = (slot == SYS_LAST);
            ctl.last = (slot == SYS_LAST);
            ctl.cevt = (slot == SYS_LAST);
         end
         CM_SYS_OFS: begin
            ctl.src   = (slot < ZERO_END) ? SRC_AIN : SRC_REF;
            ctl.zcap  = (slot == ZERO_LAST);
            ctl.fcap  = (slot == SELF_LAST);
            ctl.fdiff = 1'b1;
            ctl.last  = (slot == SELF_LAST);
            ctl.cevt  = (slot == SELF_LAST);
         end
         CM_BACKGND: begin
            if (slot == BG_ZERO)
               ctl.src = SRC_SHORT;
            else if (slot == BG_FULL)
               ctl.src = SRC_REF;
            else
               ctl.src = SRC_AIN;
            ctl.oevt = (slot == BG_OUT);
            ctl.zcap = (slot == BG_ZERO);
            ctl.fcap = (slot == BG_FULL);
            ctl.last = (slot == BG_FULL);
         end
         default: begin
            ctl.oevt = 1'b1;
            ctl.last = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/cal_coef_regs.sv
module cal_coef_regs #(
   parameter int DATA_W        = 24,
   parameter bit OFS_SPAN_DIFF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              zcap,
   input  logic              fcap,
   input  logic              fdiff,
   input  logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] zero_q,
   output logic [DATA_W-1:0] full_q
);

   logic [DATA_W-1:0] full_d;

   generate
      if (OFS_SPAN_DIFF) begin : g_span
         assign full_d = fdiff ? (data - zero_q) : data;
      end else begin : g_raw
         logic unused_fdiff;
         assign unused_fdiff = fdiff;
         assign full_d = data;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zero_q <= '0;
         full_q <= '0;
      end else begin
         if (zcap) zero_q <= data;
         if (fcap) full_q <= full_d;
      end
   end

endmodule

// File: rtl/cal_sequencer.sv
module cal_sequencer
   import cal_seq_pkg::*;
#(
   parameter int DATA_W        = 24,
   parameter int ZERO_LEN      = 4,
   parameter int SELF_LEN      = 9,
   parameter int SYS_LEN       = 4,
   parameter int BG_NORM       = 4,
   parameter bit OFS_SPAN_DIFF = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic [2:0]        mode_code,
   input  logic              period_tick,
   input  logic [DATA_W-1:0] conv_data,
   input  logic              rd_ack,
   output logic              conv_req,
   output logic [1:0]        src_sel,
   output logic [DATA_W-1:0] zero_coef,
   output logic [DATA_W-1:0] full_coef,
   output logic [DATA_W-1:0] dout,
   output logic              dout_invalid,
   output logic              drdy_n
);

   localparam int BG_LEN  = BG_NORM + 2;
   localparam int MAX_LEN = (SELF_LEN > BG_LEN) ? SELF_LEN : BG_LEN;
   localparam int SLOT_W  = $clog2(MAX_LEN + 1);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("cal_sequencer: DATA_W must be at least 2");
      end
      if (ZERO_LEN < 1 || ZERO_LEN >= SELF_LEN) begin : g_bad_self
         $error("cal_sequencer: ZERO_LEN must lie in 1..SELF_LEN-1");
      end
      if (SYS_LEN < 1) begin : g_bad_sys
         $error("cal_sequencer: SYS_LEN must be at least 1");
      end
      if (BG_NORM < 1) begin : g_bad_bg
         $error("cal_sequencer: BG_NORM must be at least 1");
      end
   endgenerate

   cal_mode_t         mode_q;
   cal_mode_t         pend_mode;
   logic [2:0]        pend_code_q;
   logic              pend_q;
   logic              active_q;
   logic              first_bg_q;
   logic [SLOT_W-1:0] slot_q;
   slot_ctl_t         ctl;
   logic              proc;

   cal_mode_decode u_dec (
      .code (pend_code_q),
      .mode (pend_mode)
   );

   cal_slot_plan #(
      .ZERO_LEN (ZERO_LEN),
      .SELF_LEN (SELF_LEN),
      .SYS_LEN  (SYS_LEN),
      .BG_NORM  (BG_NORM),
      .SLOT_W   (SLOT_W)
   ) u_plan (
      .mode (mode_q),
      .slot (slot_q),
      .ctl  (ctl)
   );

   assign proc = period_tick && !pend_q && active_q;

   cal_coef_regs #(
      .DATA_W        (DATA_W),
      .OFS_SPAN_DIFF (OFS_SPAN_DIFF)
   ) u_coef (
      .clk    (clk),
      .rst_n  (rst_n),
      .zcap   (proc && ctl.zcap),
      .fcap   (proc && ctl.fcap),
      .fdiff  (ctl.fdiff),
      .data   (conv_data),
      .zero_q (zero_coef),
      .full_q (full_coef)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_code_q <= 3'b000;
      end else if (mode_wr) begin
         pend_q      <= 1'b1;
         pend_code_q <= mode_code;
      end else if (period_tick) begin
         pend_q      <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= CM_NORM;
         active_q   <= 1'b0;
         slot_q     <= '0;
         first_bg_q <= 1'b0;
      end else if (period_tick) begin
         if (pend_q) begin
            mode_q     <= pend_mode;
            active_q   <= 1'b1;
            slot_q     <= '0;
            first_bg_q <= (pend_mode == CM_BACKGND);
         end else if (!active_q) begin
            active_q   <= 1'b1;
            slot_q     <= '0;
         end else begin
            if (ctl.last) begin
               slot_q <= '0;
               if (ctl.cevt) mode_q <= CM_NORM;
            end else begin
               slot_q <= slot_q + 1'b1;
            end
            if (ctl.fcap) first_bg_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout         <= '0;
         dout_invalid <= 1'b0;
         drdy_n       <= 1'b1;
      end else begin
         if (proc && ctl.oevt) begin
            dout         <= conv_data;
            dout_invalid <= first_bg_q;
         end
         if (proc && (ctl.oevt || ctl.cevt))
            drdy_n <= 1'b0;
         else if (rd_ack)
            drdy_n <= 1'b1;
      end
   end

   assign conv_req = active_q;
   assign src_sel  = active_q ? ctl.src : SRC_AIN;

endmodule

// File: rtl/cal_seq_chk.sv
module cal_seq_chk #(
   parameter int DATA_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              period_tick,
   input logic              rd_ack,
   input logic              conv_req,
   input logic [1:0]        src_sel,
   input logic [DATA_W-1:0] zero_coef,
   input logic [DATA_W-1:0] full_coef,
   input logic [DATA_W-1:0] dout,
   input logic              dout_invalid,
   input logic              drdy_n
);

   AST_SRC_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      src_sel != 2'b11); // R3

   AST_ACK_RAISES_DRDY: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ack && !period_tick) |=> drdy_n); // R7

   AST_DRDY_FALLS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drdy_n) |-> $past(period_tick)); // R6

   AST_COEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !period_tick |=> ($stable(zero_coef) && $stable(full_coef))); // R4

   AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !period_tick |=> $stable(dout)); // R2

   AST_REQ_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      conv_req |=> conv_req); // R10

   AST_INVALID_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_invalid) |-> !drdy_n); // R9

endmodule

bind cal_sequencer cal_seq_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .period_tick  (period_tick),
   .rd_ack       (rd_ack),
   .conv_req     (conv_req),
   .src_sel      (src_sel),
   .zero_coef    (zero_coef),
   .full_coef    (full_coef),
   .dout         (dout),
   .dout_invalid (dout_invalid),
   .drdy_n       (drdy_n)
);

// File: tb/cal_sequencer_tb_top.sv
module cal_sequencer_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DW         = 24;

   // fields: [2:0] code, [7:4] periods, [9:8] zero src, [15:12] zero period,
   // [17:16] full src, [23:20] full period, [25:24] full kind (1 raw, 2 diff)
   localparam logic [31:0] TBL [4] = '{
      32'h01924191,   // R3 self
      32'h00004042,   // R4 system zero step
      32'h01400043,   // R4 system full step
      32'h02924094    // R5 system offset
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          mode_wr = 1'b0;
   logic [2:0]    mode_code = 3'b000;
   logic          period_tick = 1'b0;
   logic [DW-1:0] conv_data = '0;
   logic          rd_ack = 1'b0;
   logic          conv_req;
   logic [1:0]    src_sel;
   logic [DW-1:0] zero_coef, full_coef, dout;
   logic          dout_invalid, drdy_n;

   int            n_chk = 0;
   int            n_fail = 0;
   int            tcount = 1;
   int            last_t = 0;
   logic [DW-1:0] exp_zero = '0;
   logic [DW-1:0] exp_full = '0;
   bit            done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cal_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code(mode_code),
      .period_tick(period_tick), .conv_data(conv_data), .rd_ack(rd_ack),
      .conv_req(conv_req), .src_sel(src_sel), .zero_coef(zero_coef),
      .full_coef(full_coef), .dout(dout), .dout_invalid(dout_invalid),
      .drdy_n(drdy_n)
   );

   function automatic logic [DW-1:0] base(input logic [1:0] s);
      case (s)
         2'b00:   base = 24'h100000;
         2'b01:   base = 24'h200000;
         2'b10:   base = 24'h300000;
         default: base = 24'hF00000;
      endcase
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      conv_data   = base(src_sel) + DW'(tcount);
      period_tick = 1'b1;
      @(negedge clk);
      period_tick = 1'b0;
      last_t      = tcount;
      tcount++;
   endtask

   task automatic wr_mode(input logic [2:0] c);
      @(negedge clk);
      mode_wr   = 1'b1;
      mode_code = c;
      @(negedge clk);
      mode_wr   = 1'b0;
   endtask

   task automatic ack();
      @(negedge clk);
      rd_ack = 1'b1;
      @(negedge clk);
      rd_ack = 1'b0;
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 drdy_n", 32'(drdy_n), 32'd1);
      chk("R1 conv_req", 32'(conv_req), 32'd0);
      chk("R1 src_sel", 32'(src_sel), 32'd0);
      chk("R1 coefs", 32'(zero_coef) | 32'(full_coef) | 32'(dout), 32'd0);
      chk("R1 invalid", 32'(dout_invalid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk over the one-step and system sequences
      for (int i = 0; i < 4; i++) begin
         logic [31:0] v;
         int len, zs, fs, fk;
         v   = TBL[i];
         len = int'(v[7:4]);
         zs  = int'(v[15:12]);
         fs  = int'(v[23:20]);
         fk  = int'(v[25:24]);
         wr_mode(v[2:0]);
         tick();                     // R10 starting tick, result discarded
         chk("R10 req after start", 32'(conv_req), 32'd1);
         ack();
         for (int k = 1; k <= len; k++) begin
            tick();
            if (k == zs) exp_zero = base(v[9:8]) + DW'(last_t);
            if (k == fs) begin
               if (fk == 2) exp_full = base(v[17:16]) + DW'(last_t) - exp_zero;
               else         exp_full = base(v[17:16]) + DW'(last_t);
            end
            if (k == len - 1) chk("R6 drdy high in sequence", 32'(drdy_n), 32'd1);
         end
         chk("R6 drdy low at end", 32'(drdy_n), 32'd0);
         chk((i == 0) ? "R3 zero" : (i == 3) ? "R5 zero" : "R4 zero",
             32'(zero_coef), 32'(exp_zero));
         chk((i == 0) ? "R3 full" : (i == 3) ? "R5 full" : "R4 full",
             32'(full_coef), 32'(exp_full));
         ack();
         tick();
         chk("R6 back to normal dout", 32'(dout), 32'(base(2'b00) + DW'(last_t)));
         chk("R6 back to normal drdy", 32'(drdy_n), 32'd0);
      end

      // R2 normal mode, R7 data-ready handshake
      wr_mode(3'b000);
      tick();
      ack();
      chk("R7 ack raises drdy", 32'(drdy_n), 32'd1);
      tick();
      chk("R2 normal dout", 32'(dout), 32'(base(2'b00) + DW'(last_t)));
      chk("R2 normal valid", 32'(dout_invalid), 32'd0);
      chk("R2 normal drdy", 32'(drdy_n), 32'd0);
      tick();
      chk("R7 drdy held without ack", 32'(drdy_n), 32'd0);
      chk("R7 newest word", 32'(dout), 32'(base(2'b00) + DW'(last_t)));

      // R2 unlisted code behaves as normal
      wr_mode(3'b110);
      tick();
      tick();
      chk("R2 unlisted dout", 32'(dout), 32'(base(2'b00) + DW'(last_t)));
      chk("R2 unlisted coefs kept", 32'(zero_coef), 32'(exp_zero));
      chk("R2 unlisted src", 32'(src_sel), 32'd0);

      // R10 abort self-cal with a system zero step
      wr_mode(3'b001);
      tick();
      tick();
      tick();
      chk("R10 shorted source in self", 32'(src_sel), 32'd1);
      wr_mode(3'b010);
      tick();
      ack();
      for (int k = 1; k <= 4; k++) begin
         tick();
         if (k == 4) exp_zero = base(2'b00) + DW'(last_t);
         if (k == 3) chk("R10 no early finish", 32'(drdy_n), 32'd1);
      end
      chk("R10 aborted into zero step", 32'(zero_coef), 32'(exp_zero));
      chk("R10 full untouched", 32'(full_coef), 32'(exp_full));
      chk("R10 drdy at end", 32'(drdy_n), 32'd0);

      // R8 R9 background
      wr_mode(3'b101);
      tick();
      ack();
      for (int k = 1; k <= 16; k++) begin
         tick();
         if (k == 4 || k == 10 || k == 16) begin
            chk("R8 bg word", 32'(dout), 32'(base(2'b00) + DW'(last_t)));
            chk("R9 bg drdy", 32'(drdy_n), 32'd0);
            chk("R9 bg invalid flag", 32'(dout_invalid), (k == 4) ? 32'd1 : 32'd0);
            ack();
         end
         if (k == 5) begin
            exp_zero = base(2'b01) + DW'(last_t);
            chk("R8 bg zero", 32'(zero_coef), 32'(exp_zero));
         end
         if (k == 6) begin
            exp_full = base(2'b10) + DW'(last_t);
            chk("R8 bg full", 32'(full_coef), 32'(exp_full));
         end
         if (k == 9 || k == 15) chk("R8 bg rate", 32'(drdy_n), 32'd1);
      end
      chk("R9 bg coef refresh", 32'(zero_coef), 32'(base(2'b01) + DW'(last_t - 5)));

      report();
   end

endmodule